// File: doc/BRIEF.md
# Clock Calendar Counter Core

This block keeps time of day and a day/month calendar as a chain of packed-BCD counters: hundredths of a second, seconds, minutes, hours (24-hour only), day of month and month. The hundredths counter is clocked by one of two timebases. The first is a crystal tick at 32.768 kHz, brought down to 100 Hz by a fractional divider. The second is a 50 Hz mains reference on the external input. A third mode ignores time altogether and counts rising edges of the external input as a six-digit BCD event count.

Software reaches the counters through a small synchronous write port and a combinational read port that share one address. The control register holds a stop flag and the mode selection. The usual sequence is to set stop, load the fields, then clear stop. An interrupt line carries a 1 Hz square wave derived from the hundredths count. After reset, time runs at once from 1 January, 00:00:00.00, in crystal mode.

Top module: `clock_calendar_core`

## Requirements
- R1: After reset the control register reads 0x00 (stop clear, crystal mode), hundredths, seconds, minutes and hours read 0x00, and day and month read 0x01.
- R2: In crystal mode each `xtal_tick` pulse is one crystal period. The k-th hundredth step takes effect at the floor(32768*k/100)-th pulse counted since reset. Periods alternate between 327 and 328 pulses so that they average 327.68, and counting starts without any software action after reset.
- R3: In crystal and mains modes `irq_o` is high while hundredths lie in 0x00..0x49 and low for 0x50..0x99, which gives a 1 Hz, 50 % wave that starts high. In event mode `irq_o` is low.
- R4: In mains mode (mode field 01) hundredths advance once for every two rising edges of `ext_in`, and `xtal_tick` has no effect.
- R5: In event mode (mode field 1x) every rising edge of `ext_in` adds one to a six-digit BCD count. Hundredths hold the low two digits, seconds the middle two and minutes the high two, and each byte rolls over at 0x99. Hours, day and month do not change.
- R6: While the stop flag (control bit 7) is set, no counter, divider or edge phase advances. Counting resumes from the frozen state when the flag is cleared.
- R7: Values written out of range are stored as written and then incremented with BCD digit carry until they reach their rollover value. For example, seconds loaded with 0x75 step to 0x76 with no carry into minutes.
- R8: Rollover values are: hundredths 0x99, seconds and minutes 0x59, hours 0x23 to 0x00, day 0x28 in month 0x02, 0x30 in months 0x04, 0x06, 0x09 and 0x11, and 0x31 otherwise (day then returns to 0x01), and month 0x12 to 0x01.
- R9: Address map: 0 is control ({stop, 5'b0, mode[1:0]}), 1 hundredths, 2 seconds, 3 minutes, 4 hours, 5 day, 6 month. Address 7 reads 0x00. `rdata` follows `addr` within the same cycle.
- R10: A write to a field in the same cycle as an increment of that field stores the written value. Fields that are not addressed still take their normal increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| xtal_tick | input | 1 | One-cycle pulse per 32.768 kHz crystal period |
| ext_in | input | 1 | Mains reference or event input, synchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_o | output | 1 | 1 Hz square wave in the time-keeping modes |

## Verification
A software write and a timebase increment can land in the same cycle, and this is the case that matters most. The bench provokes it in mains mode. It raises `ext_in` on the second edge of a pair in the same cycle as a write to seconds, and again with a write to hundredths. It then expects the written byte in the addressed field while hundredths still roll over. The stop flag is judged the same way: edges are applied while stop is set, and the bench confirms that the count is unchanged and that the edge-pair phase did not move.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int NFIELD = 6;
  localparam int F_HUND = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HOUR = 3;
  localparam int F_DAY  = 4;
  localparam int F_MON  = 5;

  typedef logic [7:0] bcd_t;
  typedef struct packed {
    logic wrap;
    bcd_t nxt;
  } step_t;

  // One BCD step: wrap to 'first' at 'last', else add one with digit carry.
  function automatic step_t bcd_step(bcd_t v, bcd_t last, bcd_t first);
    step_t r;
    if (v == last) begin
      r.wrap = 1'b1;
      r.nxt  = first;
    end else if (v[3:0] >= 4'd9) begin
      r.wrap = 1'b0;
      r.nxt  = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r.wrap = 1'b0;
      r.nxt  = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  function automatic bcd_t month_last_day(bcd_t m);
    case (m)
      8'h02:                      return 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t field_last(int idx, logic events, bcd_t month);
    case (idx)
      F_SEC, F_MIN: return events ? 8'h99 : 8'h59;
      F_HOUR:       return 8'h23;
      F_DAY:        return month_last_day(month);
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic bcd_t field_first(int idx);
    return (idx >= F_DAY) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/cc_timebase.sv
module cc_timebase #(
  parameter int DIV_INT   = 327,
  parameter int FRAC_NUM  = 68,
  parameter int FRAC_DEN  = 100,
  parameter int MAINS_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_xtal,
  input  logic sel_mains,
  input  logic xtal_tick,
  input  logic ext_in,
  output logic tick_100,
  output logic ext_rise
);
  localparam int CW = $clog2(DIV_INT + 1);
  localparam int AW = $clog2(FRAC_DEN + FRAC_NUM);
  localparam int PW = (MAINS_DIV > 1) ? $clog2(MAINS_DIV) : 1;
  localparam logic [CW-1:0] LAST_SHORT = CW'(DIV_INT - 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(DIV_INT);
  localparam logic [PW-1:0] PH_LAST    = PW'(MAINS_DIV - 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] acc, acc_sum;
  logic          long_per, xtal_step, xtal_hit, mains_hit, ext_q;
  logic [PW-1:0] ph;

  always_comb begin
    acc_sum   = acc + AW'(FRAC_NUM);
    long_per  = (acc_sum >= AW'(FRAC_DEN));
    xtal_step = run && sel_xtal && xtal_tick;
    xtal_hit  = xtal_step && (cnt == (long_per ? LAST_LONG : LAST_SHORT));
    ext_rise  = ext_in && !ext_q;
    mains_hit = run && sel_mains && ext_rise && (ph == PH_LAST);
    tick_100  = xtal_hit || mains_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (xtal_hit) begin
      cnt <= '0;
      acc <= long_per ? acc_sum - AW'(FRAC_DEN) : acc_sum;
    end else if (xtal_step) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      ph    <= '0;
    end else begin
      ext_q <= ext_in;
      if (run && sel_mains && ext_rise)
        ph <= (ph == PH_LAST) ? '0 : ph + PW'(1);
    end
  end
endmodule

// File: rtl/cc_chain.sv
module cc_chain import cc_pkg::*; #(
  parameter int AW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                events,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          wdata,
  output bcd_t [NFIELD-1:0]   fields
);
  bcd_t              regs [NFIELD];
  bcd_t              nxt  [NFIELD];
  logic [NFIELD-1:0] wrap, inc;

  always_comb begin
    step_t s;
    for (int i = 0; i < NFIELD; i++) begin
      s       = bcd_step(regs[i], field_last(i, events, regs[F_MON]), field_first(i));
      wrap[i] = s.wrap;
      nxt[i]  = s.nxt;
      fields[i] = regs[i];
    end
    inc[0] = adv;
    for (int i = 1; i < NFIELD; i++)
      inc[i] = inc[i-1] && wrap[i-1] && (!events || i < F_HOUR);
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    localparam logic [AW-1:0] MY_ADDR = AW'(g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[g] <= field_first(g);
      else if (wr_en && addr == MY_ADDR) regs[g] <= wdata;
      else if (inc[g])                   regs[g] <= nxt[g];
    end
  end
endmodule

// File: rtl/clock_calendar_core.sv
module clock_calendar_core import cc_pkg::*; #(
  parameter int DIV_INT   = 327,
  parameter int FRAC_NUM  = 68,
  parameter int FRAC_DEN  = 100,
  parameter int MAINS_DIV = 2,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_tick,
  input  logic              ext_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq_o
);
  logic       stop_q;
  logic [1:0] mode_q;
  logic       run, sel_xtal, sel_mains, sel_events;
  logic       tick_100, ext_rise, event_step, adv;
  bcd_t [NFIELD-1:0] fld_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      mode_q <= 2'b00;
    end else if (wr_en && addr == '0) begin
      stop_q <= wdata[7];
      mode_q <= wdata[1:0];
    end
  end

  always_comb begin
    run        = !stop_q;
    sel_events = mode_q[1];
    sel_mains  = (mode_q == 2'b01);
    sel_xtal   = (mode_q == 2'b00);
    event_step = run && sel_events && ext_rise;
    adv        = tick_100 || event_step;
    irq_o      = !sel_events && (fld_bus[F_HUND] < 8'h50);
  end

  cc_timebase #(
    .DIV_INT(DIV_INT), .FRAC_NUM(FRAC_NUM),
    .FRAC_DEN(FRAC_DEN), .MAINS_DIV(MAINS_DIV)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .sel_xtal(sel_xtal),
    .sel_mains(sel_mains), .xtal_tick(xtal_tick), .ext_in(ext_in),
    .tick_100(tick_100), .ext_rise(ext_rise)
  );

  cc_chain #(.AW(ADDR_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .events(sel_events),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .fields(fld_bus)
  );

  always_comb begin
    rdata = 8'h00;
    if (addr == '0) rdata = {stop_q, 5'b0, mode_q};
    for (int i = 0; i < NFIELD; i++)
      if (addr == ADDR_W'(i + 1)) rdata = fld_bus[i];
  end
endmodule

// File: rtl/cc_checker.sv
module cc_checker import cc_pkg::*; #(
  parameter int AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     addr,
  input logic [7:0]        wdata,
  input logic              stop,
  input logic              mains,
  input logic              tick,
  input logic              rise,
  input logic              irq,
  input bcd_t [NFIELD-1:0] fld
);
  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_en) |=> $stable(fld));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> (fld[F_SEC] == $past(wdata)));

  // R8
  hund_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fld[F_HUND] == 8'h99 && !(wr_en && addr == AW'(1))) |=> (fld[F_HUND] == 8'h00));

  // R4
  mains_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mains) |-> rise);

  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(wr_en)) |-> (fld[F_HUND] == 8'h00));
endmodule

bind clock_calendar_core cc_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .stop(stop_q), .mains(sel_mains), .tick(tick_100), .rise(ext_rise),
  .irq(irq_o), .fld(fld_bus)
);

// File: tb/clock_calendar_core_test.sv
module clock_calendar_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal_tick = 1'b0;
  logic       ext_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  int nedge  = 0;
  bit done   = 1'b0;

  typedef struct {
    int         a;      // 0..7 register, 8 = irq_o
    logic [7:0] e;
    string      tag;
  } item_t;
  item_t sbq[$];

  clock_calendar_core uut (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .ext_in(ext_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n && xtal_tick) nedge <= nedge + 1;

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = sbq.pop_front();
      got = (it.a == 8) ? {7'b0, irq_o} : rdata;
      checks++;
      if (got !== it.e) begin
        errors++;
        $display("FAIL %s addr=%0d got=%h exp=%h", it.tag, it.a, got, it.e);
      end
    end
  end

  task automatic expect_val(int a, logic [7:0] e, string tag);
    item_t it;
    if (a < 8) addr = 3'(a);
    it.a = a; it.e = e; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic wr(int a, logic [7:0] d);
    addr = 3'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    ext_in = 1'b1;
    repeat (2) @(posedge clk); #1;
    ext_in = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic load(logic [7:0] mode, logic [7:0] h, logic [7:0] s, logic [7:0] m,
                      logic [7:0] hr, logic [7:0] d, logic [7:0] mo);
    wr(0, 8'h80 | mode);
    wr(1, h); wr(2, s); wr(3, m); wr(4, hr); wr(5, d); wr(6, mo);
    wr(0, mode);
  endtask

  task automatic wait_until(int n);
    while (nedge < n) begin @(posedge clk); #1; end
  endtask

  // Bench restatement of the divider: hundredth steps seen after n crystal pulses.
  function automatic logic [7:0] hund_after(int n);
    int k;
    k = (100 * (n + 1) - 1) / 32768;
    k = k % 100;
    return 8'((k / 10) * 16 + (k % 10));
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_val(0, 8'h00, "R1 ctrl");
    expect_val(1, 8'h00, "R1 hund");
    expect_val(2, 8'h00, "R1 sec");
    expect_val(3, 8'h00, "R1 min");
    expect_val(4, 8'h00, "R1 hour");
    expect_val(5, 8'h01, "R1 day");
    expect_val(6, 8'h01, "R1 month");
    expect_val(8, 8'h01, "R3 irq starts high");
    expect_val(7, 8'h00, "R9 unused address");

    // R2 fractional divider, R3 square wave
    xtal_tick = 1'b1;
    wait_until(326);   expect_val(1, hund_after(326),   "R2 before first step");
    wait_until(327);   expect_val(1, hund_after(327),   "R2 first step at 327");
    wait_until(654);   expect_val(1, hund_after(654),   "R2 long period");
    wait_until(655);   expect_val(1, hund_after(655),   "R2 second step at 655");
    wait_until(16383); expect_val(8, 8'h01,             "R3 irq high first half");
    wait_until(16384); expect_val(8, 8'h00,             "R3 irq low second half");
    wait_until(16385); expect_val(1, hund_after(16385), "R3 hund at half second");
    wait_until(32767); expect_val(1, hund_after(32767), "R2 end of first second");
    wait_until(32768); expect_val(8, 8'h01,             "R3 irq high again");
    wait_until(32769); expect_val(2, 8'h01,             "R2 one second elapsed");
    xtal_tick = 1'b0;

    // R4 mains mode, R8 Feb 28 end-of-day rollover
    load(8'h01, 8'h99, 8'h59, 8'h59, 8'h23, 8'h28, 8'h02);
    expect_val(0, 8'h01, "R9 ctrl readback mains");
    xtal_tick = 1'b1;
    repeat (400) @(posedge clk); #1;
    xtal_tick = 1'b0;
    expect_val(1, 8'h99, "R4 crystal ignored in mains mode");
    pulse();
    expect_val(1, 8'h99, "R4 one edge is not a step");
    pulse();
    expect_val(1, 8'h00, "R8 hund wrap");
    expect_val(2, 8'h00, "R8 sec wrap");
    expect_val(3, 8'h00, "R8 min wrap");
    expect_val(4, 8'h00, "R8 hour wrap");
    expect_val(5, 8'h01, "R8 Feb 28 day wrap");
    expect_val(6, 8'h03, "R8 month to March");

    load(8'h01, 8'h99, 8'h59, 8'h59, 8'h23, 8'h30, 8'h04);
    pulse(); pulse();
    expect_val(5, 8'h01, "R8 April 30 day wrap");
    expect_val(6, 8'h05, "R8 month to May");

    load(8'h01, 8'h99, 8'h59, 8'h59, 8'h23, 8'h30, 8'h01);
    pulse(); pulse();
    expect_val(5, 8'h31, "R8 January reaches 31");
    expect_val(6, 8'h01, "R8 January kept");

    load(8'h01, 8'h99, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12);
    pulse(); pulse();
    expect_val(5, 8'h01, "R8 year end day");
    expect_val(6, 8'h01, "R8 month 12 to 01");

    // R6 stop freezes count and edge phase
    load(8'h01, 8'h20, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    pulse();
    wr(0, 8'h81);
    pulse(); pulse(); pulse();
    expect_val(1, 8'h20, "R6 frozen while stopped");
    wr(0, 8'h01);
    pulse();
    expect_val(1, 8'h21, "R6 phase kept across stop");

    // R7 out-of-range value stepped through
    load(8'h01, 8'h99, 8'h75, 8'h10, 8'h00, 8'h01, 8'h01);
    pulse(); pulse();
    expect_val(2, 8'h76, "R7 illegal seconds step");
    expect_val(3, 8'h10, "R7 no carry to minutes");

    // R10 write in same cycle as an increment
    load(8'h01, 8'h99, 8'h10, 8'h05, 8'h00, 8'h01, 8'h01);
    pulse();
    ext_in = 1'b1; addr = 3'd2; wdata = 8'h42; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    ext_in = 1'b0;
    repeat (2) @(posedge clk); #1;
    expect_val(1, 8'h00, "R10 hund still rolls");
    expect_val(2, 8'h42, "R10 written seconds win");
    expect_val(3, 8'h05, "R10 minutes untouched");
    pulse();
    ext_in = 1'b1; addr = 3'd1; wdata = 8'h37; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    ext_in = 1'b0;
    repeat (2) @(posedge clk); #1;
    expect_val(1, 8'h37, "R10 written hund wins");

    // R5 event counting
    load(8'h02, 8'h99, 8'h99, 8'h00, 8'h12, 8'h15, 8'h07);
    expect_val(8, 8'h00, "R3 irq low in event mode");
    pulse();
    expect_val(1, 8'h00, "R5 low digits wrap");
    expect_val(2, 8'h00, "R5 middle digits wrap");
    expect_val(3, 8'h01, "R5 high digits step");
    expect_val(4, 8'h12, "R5 hour untouched");
    expect_val(5, 8'h15, "R5 day untouched");
    pulse();
    expect_val(1, 8'h01, "R5 each edge counts");
    wr(0, 8'h83);
    expect_val(0, 8'h83, "R9 ctrl readback stop and mode");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired (all requirements) got=hung exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule